// File: doc/BRIEF.md
# Thread Stall Timer

This block holds one hardware thread idle for a requested number of clock cycles. Software asks for a stall by writing a 64-bit cycle count. The block keeps only the count divided by eight, so the timer is coarse and cheap. A counter then steps down once every eight cycles, and the stall output stays high until that counter reaches zero.

Any request smaller than one eight-cycle grain, zero included, still produces a stall of exactly one cycle. A disrupting trap or interrupt ends the stall at once. A new request made while a stall is running replaces the old one and starts its timing again from the new write.

Top module: `pause_stall_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `stall_o` is low.
- R2: A write of value V with V >= 8 keeps `stall_o` high for exactly 8*floor(V/8) consecutive cycles. The low three bits of V are discarded.
- R3: `stall_o` is high in the cycle that follows an accepted write (a write with `trap_i` low).
- R4: A write of any value below 8, including zero, keeps `stall_o` high for exactly one cycle.
- R5: The internal grain counter steps down once every 8 cycles. The eighth-cycle phase restarts at every write, so the first step comes 8 cycles after the write.
- R6: `trap_i` high in a cycle forces `stall_o` low in the next cycle. Trap takes priority over a write in the same cycle, and that write is discarded.
- R7: A write made while a stall is active reloads the timer. The stall then lasts the length set by the new value, counted from the new write.
- R8: `trap_i` while no stall is active has no effect. `stall_o` stays low, and a later write stalls for its normal length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_wr_i | input | 1 | Write strobe for a stall request |
| pause_data_i | input | 64 | Requested stall length in cycles |
| trap_i | input | 1 | Disrupting trap or interrupt; ends the stall |
| stall_o | output | 1 | High while the thread must stay idle |

## Verification
The corner that is hardest to reach from the ports is a reload that lands partway through an eight-cycle phase with a large count still pending. If the phase were not restarted, the next step would arrive early, yet the output would look the same for several cycles. The stimulus starts a long stall, waits a number of cycles that is not a multiple of eight, and writes a short value. It then measures the remaining stall length exactly. A trap that arrives together with a write, and a trap that arrives while idle, are driven in directed steps. In each case the bench confirms that the stall stays low.

// File: rtl/pause_stall_pkg.sv
package pause_stall_pkg;
  localparam int unsigned PS_DATA_W    = 64;
  localparam int unsigned PS_GRAIN_LOG = 3;
endpackage

// File: rtl/pause_prescale.sv
module pause_prescale #(
  parameter int unsigned GRAIN_LOG = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart_i,
  output logic [GRAIN_LOG-1:0] phase_o,
  output logic                 tick_o
);
  localparam logic [GRAIN_LOG-1:0] PHASE_LAST = '1;

  logic [GRAIN_LOG-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end

  assign phase_o = phase_q;
  assign tick_o  = (phase_q == PHASE_LAST);
endmodule

// File: rtl/pause_grain_count.sv
module pause_grain_count #(
  parameter int unsigned CNT_W = 61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pause_stall_unit.sv
module pause_stall_unit
  import pause_stall_pkg::*;
#(
  parameter int unsigned DATA_W    = PS_DATA_W,
  parameter int unsigned GRAIN_LOG = PS_GRAIN_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pause_wr_i,
  input  logic [DATA_W-1:0] pause_data_i,
  input  logic              trap_i,
  output logic              stall_o
);
  localparam int unsigned CNT_W = DATA_W - GRAIN_LOG;

  // Number of whole grains in a requested cycle count.
  function automatic logic [CNT_W-1:0] grains_of(input logic [DATA_W-1:0] cycles);
    return cycles[DATA_W-1:GRAIN_LOG];
  endfunction

  // True when the request is shorter than one grain.
  function automatic logic below_grain(input logic [DATA_W-1:0] cycles);
    return cycles < DATA_W'(1 << GRAIN_LOG);
  endfunction

  // Named internal events, observed by the bound checker.
  logic                 accept_wr;
  logic                 tick;
  logic                 cnt_zero;
  logic [CNT_W-1:0]     cnt_q;
  logic [GRAIN_LOG-1:0] phase_q;
  logic                 short_q;

  assign accept_wr = pause_wr_i && !trap_i;

  pause_prescale #(.GRAIN_LOG(GRAIN_LOG)) prescale_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (pause_wr_i),
    .phase_o   (phase_q),
    .tick_o    (tick)
  );

  pause_grain_count #(.CNT_W(CNT_W)) count_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (trap_i),
    .load_i     (pause_wr_i),
    .load_val_i (grains_of(pause_data_i)),
    .tick_i     (tick),
    .cnt_o      (cnt_q),
    .zero_o     (cnt_zero)
  );

  // One-cycle stall for sub-grain requests.
  always_ff @(posedge clk) begin
    if (!rst_n) short_q <= 1'b0;
    else        short_q <= accept_wr && below_grain(pause_data_i);
  end

  assign stall_o = !cnt_zero || short_q;
endmodule

// File: rtl/pause_stall_unit_chk.sv
module pause_stall_unit_chk #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned GRAIN_LOG = 3,
  parameter int unsigned CNT_W     = DATA_W - GRAIN_LOG
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pause_wr_i,
  input logic [DATA_W-1:0]    pause_data_i,
  input logic                 trap_i,
  input logic                 stall_o,
  input logic                 tick,
  input logic [CNT_W-1:0]     cnt_q,
  input logic [GRAIN_LOG-1:0] phase_q
);
  localparam logic [DATA_W-1:0] GRAIN = DATA_W'(1 << GRAIN_LOG);

  a_r3_stall_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_wr_i && !trap_i) |=> stall_o);

  a_r6_trap_releases: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> !stall_o);

  a_r4_short_single: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_wr_i && $past(pause_wr_i && !trap_i && pause_data_i < GRAIN)) |=> !stall_o);

  a_r5_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    pause_wr_i |=> (phase_q == '0));

  a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_wr_i && !trap_i && !tick) |=> $stable(cnt_q));

  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_wr_i && !trap_i && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

bind pause_stall_unit pause_stall_unit_chk #(
  .DATA_W(DATA_W), .GRAIN_LOG(GRAIN_LOG), .CNT_W(CNT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .pause_wr_i   (pause_wr_i),
  .pause_data_i (pause_data_i),
  .trap_i       (trap_i),
  .stall_o      (stall_o),
  .tick         (tick),
  .cnt_q        (cnt_q),
  .phase_q      (phase_q)
);

// File: tb/pause_stall_unit_tb_top.sv
module pause_stall_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pause_wr_i = 1'b0;
  logic [63:0] pause_data_i = '0;
  logic        trap_i = 1'b0;
  logic        stall_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk; // 50 MHz

  pause_stall_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pause_wr_i   (pause_wr_i),
    .pause_data_i (pause_data_i),
    .trap_i       (trap_i),
    .stall_o      (stall_o)
  );

  // {requested cycles, expected stall length}
  localparam logic [95:0] VEC [0:7] = '{
    {64'd0,     32'd1},
    {64'd7,     32'd1},
    {64'd8,     32'd8},
    {64'd15,    32'd8},
    {64'd128,   32'd128},
    {64'd1000,  32'd1000},
    {64'd3,     32'd1},
    {64'd16384, 32'd16384}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply a one-cycle write; returns at the first negedge after it is taken.
  task automatic do_write(input logic [63:0] d);
    @(negedge clk);
    pause_wr_i   = 1'b1;
    pause_data_i = d;
    @(negedge clk);
    pause_wr_i   = 1'b0;
  endtask

  task automatic measure(output int len);
    len = 0;
    while (stall_o && len < 40000) begin
      len++;
      @(negedge clk);
    end
  endtask

  function automatic int expect_len(input logic [63:0] d);
    return (d < 64'd8) ? 1 : int'((d / 64'd8) * 64'd8);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int len;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(stall_o == 1'b0, "R1 stall in reset", stall_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(stall_o == 1'b0, "R1 stall after reset", stall_o, 0);

    // Table walk: R2, R3, R4, R5
    for (int i = 0; i < 8; i++) begin
      logic [63:0] d;
      int          e;
      d = VEC[i][95:32];
      e = int'(VEC[i][31:0]);
      do_write(d);
      check(stall_o == 1'b1, "R3 stall after write", stall_o, 1);
      measure(len);
      check(len == e, (d < 8) ? "R4 short stall length" : "R2/R5 stall length", len, e);
      check(expect_len(d) == e, "R2 table consistency", expect_len(d), e);
      repeat (2) @(negedge clk);
    end

    // R6: trap during a long stall
    do_write(64'd1024);
    repeat (20) @(negedge clk);
    check(stall_o == 1'b1, "R6 stalled before trap", stall_o, 1);
    trap_i = 1'b1;
    @(negedge clk);
    trap_i = 1'b0;
    check(stall_o == 1'b0, "R6 trap releases stall", stall_o, 0);
    repeat (10) @(negedge clk);
    check(stall_o == 1'b0, "R6 stays released", stall_o, 0);

    // R6: trap with a simultaneous write discards the write
    @(negedge clk);
    trap_i = 1'b1; pause_wr_i = 1'b1; pause_data_i = 64'd512;
    @(negedge clk);
    trap_i = 1'b0; pause_wr_i = 1'b0;
    check(stall_o == 1'b0, "R6 trap beats write", stall_o, 0);
    repeat (12) @(negedge clk);
    check(stall_o == 1'b0, "R6 write discarded", stall_o, 0);

    // R8: trap while idle, then a normal write
    trap_i = 1'b1;
    @(negedge clk);
    trap_i = 1'b0;
    check(stall_o == 1'b0, "R8 idle trap no stall", stall_o, 0);
    do_write(64'd64);
    measure(len);
    check(len == 64, "R8 write after idle trap", len, 64);

    // R7 and R5: reload mid-phase restarts timing from the new write
    do_write(64'd800);
    repeat (29) @(negedge clk);
    do_write(64'd16);
    measure(len);
    check(len == 16, "R7/R5 reload length", len, 16);

    // R7: reload with a sub-grain value during a stall
    do_write(64'd400);
    repeat (13) @(negedge clk);
    do_write(64'd5);
    measure(len);
    check(len == 1, "R7/R4 reload short", len, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule